// File: doc/BRIEF.md
# Kernel Stack Limit Guard

This block watches every stack push of a 16-bit processor that runs in kernel, supervisor or user mode. Each push made in kernel mode has its byte address compared, unsigned, against a programmable limit. The limit is built from an 8-bit register value that supplies the upper byte, with the lower byte taken as all ones. A push above the limit is left alone. A push at or slightly below the limit is allowed to complete, and a warning trap is requested once the current instruction has ended. A push deep below the limit is fatal. In that case an abort is requested at once and an emergency stack is built.

To build the emergency stack, a small sequencer forces the stack pointer to 4. It then pushes the saved status word and the saved program counter through its own write port and signals that it is done. While this runs, the block reports busy and checks no push at all, including its own. No restart information is kept for a fatal abort. The trap vector fetch and the rest of the trap sequencing belong to the surrounding processor.

Top module: `stklim_guard`

## Requirements
- R1: After reset, `yellow_trap`, `red_abort`, `busy`, `emg_sp_wr`, `emg_push_vld` and `emg_done` are all 0.
- R2: A kernel push (`mode` = 2'b00) to an address above the limit raises neither `yellow_trap` nor `red_abort`.
- R3: The limit is {`limit_hi`, 8'hFF}. An address equal to it counts as a violation, and one greater by one does not. The comparison is unsigned.
- R4: A kernel push whose address A satisfies limit−31 ≤ A ≤ limit arms a pending warning. `yellow_trap` pulses for exactly one cycle, in the cycle after the first `instr_end` strobe that comes at least one cycle after that push.
- R5: A kernel push whose address is at most limit−32 (16 words below the limit) raises `red_abort` for exactly one cycle, in the cycle after the push.
- R6: Pushes in supervisor (2'b01), user (2'b11) or the reserved mode (2'b10) are never checked.
- R7: When a red push coincides with the `instr_end` that would deliver a pending warning, only `red_abort` is raised. The pending warning is discarded and does not fire later.
- R8: The emergency sequence runs as follows. In the `red_abort` cycle, `emg_sp_wr` is 1 and `emg_sp_val` = 4. The next cycle writes the status word captured at the red push to address 2. The cycle after that writes the captured program counter to address 0. Then `emg_done` pulses, and in the following cycle `busy` is 0. `busy` is 1 for all four of these cycles.
- R9: Pushes presented while `busy` is 1 are exempt. They cause no `red_abort` and no pending warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Current mode: 00 kernel, 01 supervisor, 11 user, 10 reserved |
| push_vld | input | 1 | A stack push happens this cycle |
| push_addr | input | 16 | Byte address of the push |
| limit_hi | input | 8 | Upper byte of the stack limit |
| instr_end | input | 1 | Current instruction completes this cycle |
| psw_in | input | 16 | Status word to save on a fatal abort |
| pc_in | input | 16 | Program counter to save on a fatal abort |
| yellow_trap | output | 1 | One-cycle warning trap request |
| red_abort | output | 1 | One-cycle fatal abort request |
| busy | output | 1 | Emergency sequence in progress |
| emg_sp_wr | output | 1 | Write `emg_sp_val` into the stack pointer |
| emg_sp_val | output | 16 | Forced stack pointer value |
| emg_push_vld | output | 1 | Emergency push write strobe |
| emg_push_addr | output | 16 | Emergency push byte address |
| emg_push_data | output | 16 | Emergency push data |
| emg_done | output | 1 | Emergency stack complete |

## Verification
Two events can meet in one cycle: the delivery of a pending warning and a new fatal push. The bench first arms a warning with a push in the yellow band. It then drives a red push together with `instr_end` and expects `red_abort` alone. A later `instr_end` must not bring the discarded warning back. The bench also sends pushes in the middle of the emergency sequence and checks that none of them produces an abort or a warning.

// File: rtl/stklim_pkg.sv
package stklim_pkg;

    typedef enum logic [1:0] {
        MODE_KERN = 2'b00,
        MODE_SUPV = 2'b01,
        MODE_RSVD = 2'b10,
        MODE_USER = 2'b11
    } cpu_mode_e;

    typedef enum logic [1:0] {
        ZONE_OK  = 2'd0,
        ZONE_YEL = 2'd1,
        ZONE_RED = 2'd2
    } zone_e;

    typedef enum logic [2:0] {
        EMG_IDLE = 3'd0,
        EMG_SP   = 3'd1,
        EMG_PSW  = 3'd2,
        EMG_PC   = 3'd3,
        EMG_DONE = 3'd4
    } emg_state_e;

endpackage

// File: rtl/stklim_zone.sv
module stklim_zone
    import stklim_pkg::*;
#(
    parameter int AW        = 16,
    parameter int LW        = 8,
    parameter int RED_BYTES = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] lim_hi,
    output zone_e         zone
);
    localparam int LOW_W = AW - LW;
    localparam logic [AW:0] RED_OFS = (AW+1)'(RED_BYTES);

    logic [AW:0] limit_x;
    logic [AW:0] addr_x;

    always_comb begin
        limit_x = {1'b0, lim_hi, {LOW_W{1'b1}}};
        addr_x  = {1'b0, addr};
        if (addr_x + RED_OFS <= limit_x)
            zone = ZONE_RED;
        else if (addr_x <= limit_x)
            zone = ZONE_YEL;
        else
            zone = ZONE_OK;
    end
endmodule

// File: rtl/stklim_warn.sv
module stklim_warn (
    input  logic clk,
    input  logic rst_n,
    input  logic yel_hit,
    input  logic red_hit,
    input  logic instr_end,
    output logic yellow_trap
);
    typedef struct packed {
        logic pend;
        logic trap;
    } warn_s;

    warn_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trap = st_q.pend && instr_end && !red_hit;
        if (instr_end)
            st_d.pend = 1'b0;
        if (yel_hit)
            st_d.pend = 1'b1;
        if (red_hit)
            st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign yellow_trap = st_q.trap;
endmodule

// File: rtl/stklim_emerg.sv
module stklim_emerg
    import stklim_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int EMG_SP_VAL = 4,
    parameter int WORD_BYTES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          red_hit,
    input  logic [DW-1:0] psw_in,
    input  logic [DW-1:0] pc_in,
    output logic          red_abort,
    output logic          busy,
    output logic          sp_wr,
    output logic [AW-1:0] sp_val,
    output logic          push_vld,
    output logic [AW-1:0] push_addr,
    output logic [DW-1:0] push_data,
    output logic          done
);
    localparam logic [AW-1:0] SP_FORCE = AW'(EMG_SP_VAL);
    localparam logic [AW-1:0] PSW_SLOT = AW'(EMG_SP_VAL - WORD_BYTES);
    localparam logic [AW-1:0] PC_SLOT  = AW'(EMG_SP_VAL - 2*WORD_BYTES);

    typedef struct packed {
        emg_state_e    state;
        logic          abort;
        logic [DW-1:0] psw;
        logic [DW-1:0] pc;
    } emg_s;

    emg_s st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.abort = 1'b0;
        unique case (st_q.state)
            EMG_IDLE: if (red_hit) begin
                st_d.state = EMG_SP;
                st_d.abort = 1'b1;
                st_d.psw   = psw_in;
                st_d.pc    = pc_in;
            end
            EMG_SP:   st_d.state = EMG_PSW;
            EMG_PSW:  st_d.state = EMG_PC;
            EMG_PC:   st_d.state = EMG_DONE;
            EMG_DONE: st_d.state = EMG_IDLE;
            default:  st_d.state = EMG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: EMG_IDLE, default: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        busy      = (st_q.state != EMG_IDLE);
        red_abort = st_q.abort;
        sp_wr     = (st_q.state == EMG_SP);
        sp_val    = SP_FORCE;
        done      = (st_q.state == EMG_DONE);
        push_vld  = (st_q.state == EMG_PSW) || (st_q.state == EMG_PC);
        push_addr = (st_q.state == EMG_PC) ? PC_SLOT : PSW_SLOT;
        push_data = (st_q.state == EMG_PC) ? st_q.pc : st_q.psw;
    end
endmodule

// File: rtl/stklim_guard.sv
module stklim_guard
    import stklim_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int LW         = 8,
    parameter int RED_WORDS  = 16,
    parameter int WORD_BYTES = 2,
    parameter int EMG_SP_VAL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          push_vld,
    input  logic [AW-1:0] push_addr,
    input  logic [LW-1:0] limit_hi,
    input  logic          instr_end,
    input  logic [DW-1:0] psw_in,
    input  logic [DW-1:0] pc_in,
    output logic          yellow_trap,
    output logic          red_abort,
    output logic          busy,
    output logic          emg_sp_wr,
    output logic [AW-1:0] emg_sp_val,
    output logic          emg_push_vld,
    output logic [AW-1:0] emg_push_addr,
    output logic [DW-1:0] emg_push_data,
    output logic          emg_done
);
    localparam int RED_BYTES = RED_WORDS * WORD_BYTES;

    zone_e zone;
    logic  checked, yel_hit, red_hit;

    stklim_zone #(.AW(AW), .LW(LW), .RED_BYTES(RED_BYTES)) u_zone (
        .addr   (push_addr),
        .lim_hi (limit_hi),
        .zone   (zone)
    );

    always_comb begin
        checked = push_vld && (mode == MODE_KERN) && !busy;
        red_hit = checked && (zone == ZONE_RED);
        yel_hit = checked && (zone == ZONE_YEL);
    end

    stklim_warn u_warn (
        .clk         (clk),
        .rst_n       (rst_n),
        .yel_hit     (yel_hit),
        .red_hit     (red_hit),
        .instr_end   (instr_end),
        .yellow_trap (yellow_trap)
    );

    stklim_emerg #(.AW(AW), .DW(DW), .EMG_SP_VAL(EMG_SP_VAL),
                   .WORD_BYTES(WORD_BYTES)) u_emerg (
        .clk       (clk),
        .rst_n     (rst_n),
        .red_hit   (red_hit),
        .psw_in    (psw_in),
        .pc_in     (pc_in),
        .red_abort (red_abort),
        .busy      (busy),
        .sp_wr     (emg_sp_wr),
        .sp_val    (emg_sp_val),
        .push_vld  (emg_push_vld),
        .push_addr (emg_push_addr),
        .push_data (emg_push_data),
        .done      (emg_done)
    );
endmodule

// File: rtl/stklim_guard_chk.sv
module stklim_guard_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          yellow_trap,
    input logic          red_abort,
    input logic          busy,
    input logic          emg_sp_wr,
    input logic [AW-1:0] emg_sp_val,
    input logic          emg_push_vld,
    input logic [AW-1:0] emg_push_addr,
    input logic          emg_done
);
    // R8
    abort_forces_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        red_abort |-> (emg_sp_wr && busy && emg_sp_val == AW'(4)));
    // R8
    sp_then_psw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emg_sp_wr |=> (emg_push_vld && emg_push_addr == AW'(2)));
    // R8
    psw_then_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emg_push_vld && emg_push_addr == AW'(2)) |=> (emg_push_vld && emg_push_addr == AW'(0)));
    // R8
    pc_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emg_push_vld && emg_push_addr == AW'(0)) |=> emg_done);
    // R8
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emg_done |=> !busy);
    // R7
    red_beats_yellow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({red_abort, yellow_trap}));
    // R9
    busy_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !red_abort);
endmodule

bind stklim_guard stklim_guard_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .yellow_trap   (yellow_trap),
    .red_abort     (red_abort),
    .busy          (busy),
    .emg_sp_wr     (emg_sp_wr),
    .emg_sp_val    (emg_sp_val),
    .emg_push_vld  (emg_push_vld),
    .emg_push_addr (emg_push_addr),
    .emg_done      (emg_done)
);

// File: tb/tb_stklim_guard.sv
`timescale 1ns/1ps
module tb_stklim_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        push_vld;
    logic [15:0] push_addr;
    logic [7:0]  limit_hi;
    logic        instr_end;
    logic [15:0] psw_in, pc_in;
    logic        yellow_trap, red_abort, busy, emg_sp_wr, emg_push_vld, emg_done;
    logic [15:0] emg_sp_val, emg_push_addr, emg_push_data;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    stklim_guard dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .push_vld(push_vld),
        .push_addr(push_addr), .limit_hi(limit_hi), .instr_end(instr_end),
        .psw_in(psw_in), .pc_in(pc_in), .yellow_trap(yellow_trap),
        .red_abort(red_abort), .busy(busy), .emg_sp_wr(emg_sp_wr),
        .emg_sp_val(emg_sp_val), .emg_push_vld(emg_push_vld),
        .emg_push_addr(emg_push_addr), .emg_push_data(emg_push_data),
        .emg_done(emg_done)
    );

    // class: 0 none, 1 yellow, 2 red. Fields {mode, addr, limit_hi, class}
    localparam int NV = 13;
    localparam logic [27:0] VEC [NV] = '{
        {2'b00, 16'h4100, 8'h40, 2'd0},  // R2 R3 one above limit
        {2'b00, 16'h40FF, 8'h40, 2'd1},  // R3 equal to limit
        {2'b00, 16'h40E0, 8'h40, 2'd1},  // R4 limit-31
        {2'b00, 16'h40DF, 8'h40, 2'd2},  // R5 limit-32
        {2'b00, 16'h1000, 8'h40, 2'd2},  // R5 far below
        {2'b01, 16'h1000, 8'h40, 2'd0},  // R6 supervisor
        {2'b11, 16'h40FF, 8'h40, 2'd0},  // R6 user
        {2'b10, 16'h1000, 8'h40, 2'd0},  // R6 reserved
        {2'b00, 16'hFFFF, 8'hFF, 2'd1},  // R3 top of space, unsigned
        {2'b00, 16'hFFDF, 8'hFF, 2'd2},  // R5 unsigned
        {2'b00, 16'h00E0, 8'h00, 2'd1},  // R4 low limit
        {2'b00, 16'h00DF, 8'h00, 2'd2},  // R5 low limit
        {2'b00, 16'h0100, 8'h00, 2'd0}   // R2 low limit
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        push_vld = 0; instr_end = 0;
    endtask

    task automatic push(input logic [1:0] m, input logic [15:0] a, input bit ie);
        mode = m; push_addr = a; push_vld = 1; instr_end = ie;
        tick();
        idle_in();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 0; mode = 0; push_addr = 0; limit_hi = 8'h40;
        psw_in = 16'h0000; pc_in = 16'h0000;
        idle_in();
        tick(); tick();
        // R1
        chk(!yellow_trap && !red_abort && !busy && !emg_sp_wr && !emg_push_vld && !emg_done,
            "R1", {yellow_trap, red_abort, busy, emg_sp_wr, emg_push_vld, emg_done}, 0);
        rst_n = 1;
        tick();

        for (int i = 0; i < NV; i++) begin
            limit_hi = VEC[i][9:2];
            push(VEC[i][27:26], VEC[i][25:10], 1'b0);
            chk(red_abort == (VEC[i][1:0] == 2'd2), "R5/R2/R6 red", red_abort, VEC[i][1:0]);
            instr_end = 1;
            tick();
            idle_in();
            chk(yellow_trap == (VEC[i][1:0] == 2'd1), "R4/R3/R6 yellow", yellow_trap, VEC[i][1:0]);
            repeat (5) tick();
        end

        // R4: push in the same cycle as instr_end delivers at the next one only
        limit_hi = 8'h40;
        push(2'b00, 16'h40F0, 1'b1);
        chk(!yellow_trap, "R4 same-cycle", yellow_trap, 0);
        tick();
        chk(!yellow_trap, "R4 no early", yellow_trap, 0);
        instr_end = 1; tick(); idle_in();
        chk(yellow_trap, "R4 pulse", yellow_trap, 1);
        tick();
        chk(!yellow_trap, "R4 one cycle", yellow_trap, 0);

        // R8 emergency sequence with captured values
        psw_in = 16'hA5C3; pc_in = 16'h1234;
        push(2'b00, 16'h0200, 1'b0);
        psw_in = 16'h0F0F; pc_in = 16'hBEEF;
        chk(red_abort && emg_sp_wr && emg_sp_val == 16'd4 && busy, "R8 force sp",
            {red_abort, emg_sp_wr, busy, emg_sp_val}, 20'h70004);
        // R9: a red push and a yellow push during busy
        push(2'b00, 16'h0100, 1'b0);
        chk(!red_abort && emg_push_vld && emg_push_addr == 16'd2 && emg_push_data == 16'hA5C3,
            "R8 push psw", emg_push_data, 16'hA5C3);
        push(2'b00, 16'h40FF, 1'b0);
        chk(!red_abort && emg_push_vld && emg_push_addr == 16'd0 && emg_push_data == 16'h1234,
            "R8 push pc", emg_push_data, 16'h1234);
        tick();
        chk(emg_done && busy && !emg_push_vld && !red_abort, "R8 done", {emg_done, busy}, 3);
        tick();
        chk(!busy && !emg_done && !red_abort, "R8 idle", busy, 0);
        instr_end = 1; tick(); idle_in();
        chk(!yellow_trap && !red_abort, "R9 busy pushes exempt", {yellow_trap, red_abort}, 0);

        // R7: pending warning meets a red push with instr_end
        push(2'b00, 16'h40F0, 1'b0);
        push(2'b00, 16'h0010, 1'b1);
        chk(red_abort && !yellow_trap, "R7 red wins", {red_abort, yellow_trap}, 2);
        repeat (5) tick();
        instr_end = 1; tick(); idle_in();
        chk(!yellow_trap, "R7 warning dropped", yellow_trap, 0);

        finish_run();
    end
endmodule